// File: doc/BRIEF.md
# Interrupt Enable and Event Flag Register

This block is the interrupt control register of a small microcontroller core. It is one 8-bit location on the CPU register bus. Its upper five bits are enables and its lower three bits are sticky event flags. The flags record three event sources:

- a timer overflow pulse;
- a rising edge on an asynchronous external interrupt pin;
- a change on any selected pin of an 8-bit port.

The block combines the flags with their enables under a two-level gate. A master enable sits over everything. A group enable sits over a separate peripheral request line. The result is one interrupt request to the core.

Flags latch whenever their event occurs, whatever the enable state. Software reads the register and clears each flag by writing it to 0. If an event and a clearing write land in the same cycle, the event wins. The read port is combinational and always shows the current register contents.

Top module: `intr_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00 and irqOut is 0.
- R2: A bus write (busSel and busWr high at a clock edge) stores busWdata. The new value shows on busRdata after that edge. Bit 7 is the master enable, bit 6 the group enable, bit 5 the timer enable, bit 4 the pin enable, bit 3 the port enable, bit 2 the timer flag, bit 1 the pin flag and bit 0 the port flag.
- R3: While bit 7 is 0, irqOut is 0 whatever the flags, the enables and periphReq are.
- R4: With bit 7 at 1, irqOut is 1 whenever a flag and its own enable are both 1: bits 2 and 5, bits 1 and 4, or bits 0 and 3.
- R5: periphReq raises irqOut only when bits 7 and 6 are both 1. While bit 6 is 0, periphReq has no effect on irqOut.
- R6: A tmrOvf high at a clock edge sets bit 2 at that edge, whatever the enables are.
- R7: extPin passes through a two-flop synchroniser and then an edge-detect register. A rising edge sets bit 1 at the third clock edge after the pin goes high. A falling edge sets nothing.
- R8: Bit 0 sets at the clock edge after any port pin whose portMask bit is 1 differs from its value at the previous edge. A change on a pin whose mask bit is 0 leaves bit 0 unchanged.
- R9: A set flag stays 1 until a bus write carries 0 in its position. Hardware never clears a flag.
- R10: If a flag-set event and a bus write of 0 to that flag occur at the same edge, the flag ends at 1.
- R11: While busSel or busWr is low, busWdata changes nothing in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register selected on the CPU bus |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Current register contents |
| tmrOvf | input | 1 | One-cycle timer overflow pulse |
| extPin | input | 1 | Asynchronous external interrupt pin |
| portPins | input | 8 | Port pin levels |
| portMask | input | 8 | Per-pin change-detect enable |
| periphReq | input | 1 | Combined peripheral interrupt request |
| irqOut | output | 1 | Interrupt request to the core |

## Verification
Some properties are checked at every clock edge:

- the master gate holds irqOut low;
- the group gate holds back periphReq;
- a timer pulse and a masked port change each set their flag one edge later;
- flags stay set with no bus write;
- the enable bits do not move without a bus write.

The directed scenarios cover what needs a planned stimulus:

- the exact three-edge latency of the pin path;
- that a falling pin edge is ignored;
- that masked-out port pins are ignored;
- that a set event beats a clearing write in the same cycle;
- the full combination logic behind irqOut.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;
  localparam int REG_W = 8;
  // field positions inside the register (decoded by the core's software)
  localparam int BIT_ALL  = 7;
  localparam int BIT_GRP  = 6;
  localparam int BIT_TMRE = 5;
  localparam int BIT_PINE = 4;
  localparam int BIT_PRTE = 3;
  localparam int BIT_TMRF = 2;
  localparam int BIT_PINF = 1;
  localparam int BIT_PRTF = 0;
  localparam int NUM_FLAGS = 3;

  typedef struct packed {
    logic             wrEn;
    logic [REG_W-1:0] wrData;
    logic [NUM_FLAGS-1:0] setFlag; // [2] timer, [1] pin, [0] port
  } strobe_t;
endpackage

// File: rtl/intr_ctrl_ctl.sv
module intr_ctrl_ctl
  import intr_ctrl_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              tmrOvf,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portPins,
  input  logic [PORT_W-1:0] portMask,
  output strobe_t           strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinPrev;
  logic [PORT_W-1:0]      portPrev;
  logic                   pinRise;
  logic                   portChg;

  // synchroniser chain for the asynchronous pin
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else if (s == 0) syncQ[s] <= extPin;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= syncQ[LAST];
  end

  // the previous port copy follows the pins in every cycle, reset included
  always_ff @(posedge clk) portPrev <= portPins;

  always_comb begin
    pinRise = syncQ[LAST] & ~pinPrev;
    portChg = |((portPins ^ portPrev) & portMask);
    strb.wrEn    = busSel & busWr;
    strb.wrData  = busWdata;
    strb.setFlag = {tmrOvf, pinRise, portChg};
  end
endmodule

// File: rtl/intr_ctrl_dp.sv
module intr_ctrl_dp
  import intr_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             periphReq,
  output logic [REG_W-1:0] regQ,
  output logic             irqOut
);
  localparam int EN_W = REG_W - NUM_FLAGS;

  logic [EN_W-1:0]      enQ;
  logic [NUM_FLAGS-1:0] flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          enQ <= '0;
    else if (strb.wrEn) enQ <= strb.wrData[REG_W-1:NUM_FLAGS];
  end

  // each flag: the write value, then a hardware set on top (set wins)
  generate
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flagQ[f] <= 1'b0;
        else flagQ[f] <= (strb.wrEn ? strb.wrData[f] : flagQ[f]) | strb.setFlag[f];
      end
    end
  endgenerate

  always_comb begin
    regQ = {enQ, flagQ};
    irqOut = regQ[BIT_ALL] &
             ((regQ[BIT_TMRF] & regQ[BIT_TMRE]) |
              (regQ[BIT_PINF] & regQ[BIT_PINE]) |
              (regQ[BIT_PRTF] & regQ[BIT_PRTE]) |
              (regQ[BIT_GRP]  & periphReq));
  end
endmodule

// File: rtl/intr_ctrl_reg.sv
module intr_ctrl_reg
  import intr_ctrl_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              tmrOvf,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portPins,
  input  logic [PORT_W-1:0] portMask,
  input  logic              periphReq,
  output logic              irqOut
);
  strobe_t strb;

  intr_ctrl_ctl #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) ctl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWdata(busWdata), .tmrOvf(tmrOvf), .extPin(extPin),
    .portPins(portPins), .portMask(portMask), .strb(strb)
  );

  intr_ctrl_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .periphReq(periphReq),
    .regQ(busRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/intr_ctrl_reg_chk.sv
module intr_ctrl_reg_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [7:0]        busRdata,
  input logic              tmrOvf,
  input logic [PORT_W-1:0] portPins,
  input logic [PORT_W-1:0] portMask,
  input logic              periphReq,
  input logic              irqOut
);
  logic wrNow;
  assign wrNow = busSel & busWr;

  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdata[7] |-> !irqOut);

  // R5
  grp_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periphReq && !busRdata[6] && !(busRdata[5] && busRdata[2]) &&
     !(busRdata[4] && busRdata[1]) && !(busRdata[3] && busRdata[0])) |-> !irqOut);

  // R6
  tmr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf |=> busRdata[2]);

  // R8
  port_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|((portPins ^ $past(portPins)) & portMask)) |=> busRdata[0]);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|busRdata[2:0]) && !wrNow) |=> ((busRdata[2:0] & $past(busRdata[2:0])) == $past(busRdata[2:0])));

  // R11
  no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrNow |=> $stable(busRdata[7:3]));
endmodule

bind intr_ctrl_reg intr_ctrl_reg_chk #(.PORT_W(PORT_W)) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busRdata(busRdata), .tmrOvf(tmrOvf), .portPins(portPins),
  .portMask(portMask), .periphReq(periphReq), .irqOut(irqOut)
);

// File: tb/intr_ctrl_reg_tb.sv
module intr_ctrl_reg_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic tmrOvf = 1'b0, extPin = 1'b0, periphReq = 1'b0;
  logic [7:0] portPins = 8'h00, portMask = 8'h00;
  logic irqOut;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  intr_ctrl_reg dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .tmrOvf(tmrOvf),
    .extPin(extPin), .portPins(portPins), .portMask(portMask),
    .periphReq(periphReq), .irqOut(irqOut)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all driving and checking happens at falling edges
  task automatic regWrite(logic [7:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic testReset();
    check("R1 reset value", busRdata, 8'h00);
    check("R1 reset irq", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic testWrite();
    regWrite(8'h5A); check("R2 write/readback", busRdata, 8'h5A);
    regWrite(8'h00); check("R2 write zero", busRdata, 8'h00);
    @(negedge clk); busSel = 1; busWr = 0; busWdata = 8'hFF;
    @(negedge clk); busSel = 0; busWr = 1;
    @(negedge clk); busWr = 0;
    check("R11 no write without both strobes", busRdata, 8'h00);
  endtask

  task automatic testTimer();
    regWrite(8'h00);
    @(negedge clk); tmrOvf = 1;
    @(negedge clk); tmrOvf = 0;
    check("R6 timer flag with enables off", busRdata, 8'h04);
    repeat (3) @(negedge clk);
    check("R9 timer flag sticky", busRdata, 8'h04);
    regWrite(8'h00); check("R9 cleared by write 0", busRdata, 8'h00);
  endtask

  task automatic testPin();
    @(negedge clk); extPin = 1;
    @(negedge clk); @(negedge clk);
    check("R7 no flag after two edges", busRdata, 8'h00);
    @(negedge clk);
    check("R7 flag on third edge", busRdata, 8'h02);
    regWrite(8'h00);
    @(negedge clk); extPin = 0;
    repeat (5) @(negedge clk);
    check("R7 falling edge ignored", busRdata, 8'h00);
  endtask

  task automatic testPort();
    @(negedge clk); portMask = 8'h0F;
    @(negedge clk); portPins = 8'hF0;
    @(negedge clk);
    check("R8 masked-out change ignored", busRdata, 8'h00);
    portPins = 8'hF4;
    @(negedge clk);
    check("R8 enabled pin change", busRdata, 8'h01);
    regWrite(8'h00);
    @(negedge clk);
    check("R8 no change, stays clear", busRdata, 8'h00);
  endtask

  task automatic testSetWins();
    @(negedge clk); busSel = 1; busWr = 1; busWdata = 8'h00; tmrOvf = 1;
    @(negedge clk); busSel = 0; busWr = 0; tmrOvf = 0;
    check("R10 set beats clearing write", busRdata, 8'h04);
    regWrite(8'h00);
  endtask

  task automatic testIrq();
    regWrite(8'h3F);
    check("R3 master off blocks", {7'd0, irqOut}, 8'h00);
    regWrite(8'hA4);
    check("R4 timer flag+enable", {7'd0, irqOut}, 8'h01);
    regWrite(8'h9C);
    check("R4 flag without its enable", {7'd0, irqOut}, 8'h00);
    regWrite(8'h89);
    check("R4 port flag+enable", {7'd0, irqOut}, 8'h01);
    regWrite(8'h80); periphReq = 1; #1;
    check("R5 group off blocks periph", {7'd0, irqOut}, 8'h00);
    regWrite(8'hC0); #1;
    check("R5 group on passes periph", {7'd0, irqOut}, 8'h01);
    regWrite(8'h40); #1;
    check("R3 master off blocks periph", {7'd0, irqOut}, 8'h00);
    periphReq = 0;
    regWrite(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testWrite();
    testTimer();
    testPin();
    testPort();
    testSetWins();
    testIrq();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule